// File: doc/BRIEF.md
# Unit Self-Test Sequencer

This block runs a hard-fault self-test on one sub-unit of a router at a time. Control-type units get a stream of pseudo-random words from a 32-bit maximal-length LFSR. Their replies are folded into a 32-bit multiple-input signature register (MISR), and the final signature is compared with a golden value fixed in the block at build time.

Datapath-type units get the walking-bit test. A single 1 is moved across every bit position, and then a single 0 is moved across every bit position. Every returned word must equal the word that was sent. These two tests catch stuck-at faults that comparing two copies of a unit can miss, because a fault shared by both copies looks the same in each.

A parameter mask sets the test mode for each unit. The verdict for each unit is kept in a sticky fault table, which the network reconfiguration logic reads.

The sequencer is driven by pulsing `start` while `unit_sel` names the target. The unit under test sees `stim` and answers on `resp` in the same cycle. `done` pulses when the verdict has been stored.

The state sequence is IDLE → SEED → RUN → COMPARE → WRITE → DONE → IDLE, with these transitions:
- **accept**: IDLE to SEED, when `start` is high.
- **prime**: SEED to RUN.
- **finish**: RUN to COMPARE, on the last pattern.
- **judge**: COMPARE to WRITE.
- **record**: WRITE to DONE.
- **release**: DONE to IDLE.

Top module: `bist_sequencer`

## Requirements
- R1: After reset, `stim` is 0, `done` is 0 and every `fault_bits` bit is 0.
- R2: In signature mode, the cycle after `start` is accepted is one SEED cycle with `stim` = 0. It is followed by PAT_CYCLES (256) RUN cycles. In those cycles, `stim` starts at SEED (0x00000001) and advances each cycle by a right shift, XORed with 0x80200003 whenever the bit shifted out was 1.
- R3: In signature mode, the response register is cleared in SEED. Each RUN cycle it is updated to (sig >> 1) XOR (sig[0] ? 0x80200003 : 0) XOR `resp`. In COMPARE, a signature that differs from the stored golden value for that unit marks the unit as failed.
- R4: In walking mode, RUN lasts 2×W (64) cycles. In cycle k < W, `stim` is 1 << k. In cycle k ≥ W, `stim` is ~(1 << (k−W)). Any cycle where `resp` differs from `stim` marks the unit as failed.
- R5: A failed test sets `fault_bits[unit]` and nothing else. A passing test leaves the bit unchanged. Only reset clears a bit.
- R6: The states follow IDLE→SEED→RUN→COMPARE→WRITE→DONE→IDLE. `stim` is 0 outside RUN. `done` is high for exactly the one DONE cycle, and the new fault bit is visible in that same cycle.
- R7: `start` and `unit_sel` are ignored in every state but IDLE. `start` held high through DONE begins the next test only after one IDLE cycle.
- R8: Bit `unit_sel` of the DP_MASK parameter picks the mode: 1 selects walking mode, 0 selects signature mode. Default mask 4'b1100 makes units 2 and 3 datapaths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test (honoured in IDLE only) |
| unit_sel | input | UW (2) | Index of the unit to test |
| stim | output | W (32) | Pattern applied to the unit under test |
| resp | input | W (32) | Reply of the unit under test, same cycle |
| done | output | 1 | One-cycle pulse when the verdict is stored |
| fault_bits | output | NUM_UNITS (4) | Sticky per-unit fault flags |

## Verification
The bench attacks the following corner cases. Each one names the bad behaviour it is meant to expose.

- **Stuck-at-1 on a control unit:** checks the signature path. A design whose compactor or golden lookup is wrong would either miss this fault or flag a healthy unit.
- **Stuck-at-1 at bit 0 on a datapath, and stuck-at-0 at bit 31:** these sit on the first and last walking positions. They expose an off-by-one in the pattern counter, or a walking-zero half that is never applied.
- **Clean retest of a unit already marked faulty:** catches a table that rewrites or clears a bit on a pass.
- **Start pulse aimed at a clean datapath in the middle of a test:** a design that re-latches the selection would record the verdict against the wrong unit.
- **Start held high across two tests:** a design that skips the IDLE cycle would misalign every later pattern.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_RUN,
        ST_COMPARE,
        ST_WRITE,
        ST_DONE
    } bist_state_e;

    typedef enum logic {
        MODE_SIG,
        MODE_WALK
    } test_mode_e;

endpackage

// File: rtl/bist_stim_gen.sv
module bist_stim_gen
    import bist_pkg::*;
#(
    parameter int          W          = 32,
    parameter int          PAT_CYCLES = 256,
    parameter logic [W-1:0] SEED      = 32'h0000_0001,
    parameter logic [W-1:0] POLY      = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  test_mode_e   mode,
    output logic [W-1:0] pattern,
    output logic         last
);
    localparam int WALK_CYCLES = 2 * W;
    localparam int MAX_CYCLES  = (WALK_CYCLES > PAT_CYCLES) ? WALK_CYCLES : PAT_CYCLES;
    localparam int CW          = $clog2(MAX_CYCLES);
    localparam int IW          = $clog2(W);

    logic [W-1:0]  lfsr_q;
    logic [W-1:0]  lfsr_nxt;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] bit_idx;
    logic          zero_phase;
    logic [W-1:0]  walk_one;

    always_comb begin
        lfsr_nxt = (lfsr_q >> 1) ^ (lfsr_q[0] ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            cnt_q  <= '0;
        end else if (load) begin
            lfsr_q <= SEED;
            cnt_q  <= '0;
        end else if (step) begin
            lfsr_q <= lfsr_nxt;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        bit_idx    = cnt_q[IW-1:0];
        zero_phase = (cnt_q >= CW'(W));
        walk_one   = W'(1) << bit_idx;
        if (mode == MODE_WALK) begin
            pattern = zero_phase ? ~walk_one : walk_one;
            last    = (cnt_q == CW'(WALK_CYCLES - 1));
        end else begin
            pattern = lfsr_q;
            last    = (cnt_q == CW'(PAT_CYCLES - 1));
        end
    end

    // R2
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (lfsr_q != '0));

    // R4
    walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_WALK) |-> (cnt_q < CW'(WALK_CYCLES)));

endmodule

// File: rtl/bist_resp_compactor.sv
module bist_resp_compactor #(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic [W-1:0] stim,
    input  logic [W-1:0] resp,
    output logic [W-1:0] sig,
    output logic         miss
);
    logic [W-1:0] sig_nxt;

    always_comb begin
        sig_nxt = ((sig >> 1) ^ (sig[0] ? POLY : '0)) ^ resp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sig  <= '0;
            miss <= 1'b0;
        end else if (capture) begin
            sig <= sig_nxt;
            if (resp != stim) begin
                miss <= 1'b1;
            end
        end
    end

    // R4
    miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !clear) |=> miss);

endmodule

// File: rtl/bist_fault_table.sv
module bist_fault_table #(
    parameter int NUM_UNITS = 4,
    parameter int UW        = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [UW-1:0]        idx,
    input  logic                 fail,
    output logic [NUM_UNITS-1:0] bits
);
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits[g] <= 1'b0;
            end else if (wr && fail && (idx == UW'(g))) begin
                bits[g] <= 1'b1;
            end
        end
    end

    // R5
    no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bits & $past(bits)) == $past(bits)));

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
    import bist_pkg::*;
#(
    parameter int                           W          = 32,
    parameter int                           NUM_UNITS  = 4,
    parameter int                           PAT_CYCLES = 256,
    parameter logic [W-1:0]                 SEED       = 32'h0000_0001,
    parameter logic [W-1:0]                 POLY       = 32'h8020_0003,
    parameter logic [NUM_UNITS-1:0]         DP_MASK    = 4'b1100,
    parameter logic [NUM_UNITS-1:0][W-1:0]  EXP_SIG    = '0,
    localparam int                          UW         = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [UW-1:0]        unit_sel,
    output logic [W-1:0]         stim,
    input  logic [W-1:0]         resp,
    output logic                 done,
    output logic [NUM_UNITS-1:0] fault_bits
);
    bist_state_e   state_q, state_d;
    logic [UW-1:0] unit_q;
    test_mode_e    mode_q;
    logic          fail_q;

    logic          gen_load, gen_step, gen_last;
    logic [W-1:0]  gen_pattern;
    logic          cmp_clear, cmp_capture, cmp_miss;
    logic [W-1:0]  cmp_sig;
    logic          tbl_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SEED;
            ST_SEED:    state_d = ST_RUN;
            ST_RUN:     if (gen_last) state_d = ST_COMPARE;
            ST_COMPARE: state_d = ST_WRITE;
            ST_WRITE:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // job registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_q <= '0;
            mode_q <= MODE_SIG;
            fail_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                unit_q <= unit_sel;
                mode_q <= DP_MASK[unit_sel] ? MODE_WALK : MODE_SIG;
            end
            if (state_q == ST_COMPARE) begin
                fail_q <= (mode_q == MODE_WALK) ? cmp_miss : (cmp_sig != EXP_SIG[unit_q]);
            end
        end
    end

    // outputs
    always_comb begin
        gen_load    = 1'b0;
        gen_step    = 1'b0;
        cmp_clear   = 1'b0;
        cmp_capture = 1'b0;
        tbl_wr      = 1'b0;
        done        = 1'b0;
        stim        = '0;
        unique case (state_q)
            ST_SEED: begin
                gen_load  = 1'b1;
                cmp_clear = 1'b1;
            end
            ST_RUN: begin
                gen_step    = 1'b1;
                cmp_capture = 1'b1;
                stim        = gen_pattern;
            end
            ST_WRITE: tbl_wr = 1'b1;
            ST_DONE:  done   = 1'b1;
            default: ;
        endcase
    end

    bist_stim_gen #(
        .W(W), .PAT_CYCLES(PAT_CYCLES), .SEED(SEED), .POLY(POLY)
    ) i_stim_gen (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .mode(mode_q), .pattern(gen_pattern), .last(gen_last)
    );

    bist_resp_compactor #(
        .W(W), .POLY(POLY)
    ) i_compactor (
        .clk(clk), .rst_n(rst_n), .clear(cmp_clear), .capture(cmp_capture),
        .stim(gen_pattern), .resp(resp), .sig(cmp_sig), .miss(cmp_miss)
    );

    bist_fault_table #(
        .NUM_UNITS(NUM_UNITS), .UW(UW)
    ) i_fault_table (
        .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .idx(unit_q),
        .fail(fail_q), .bits(fault_bits)
    );

    // R6
    seed_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |=> (state_q == ST_RUN));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(unit_q));

    // R5
    fault_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_bits != $past(fault_bits)) |-> ($past(state_q) == ST_WRITE));

endmodule

// File: tb/test_bist_sequencer.sv
`timescale 1ns/1ps
module test_bist_sequencer;
    localparam int                   W    = 32;
    localparam int                   N    = 4;
    localparam int                   PAT  = 256;
    localparam logic [W-1:0]         SEED = 32'h0000_0001;
    localparam logic [W-1:0]         POLY = 32'h8020_0003;
    localparam logic [N-1:0]         DPM  = 4'b1100;

    function automatic logic [W-1:0] good_resp(int u, logic [W-1:0] s);
        if (DPM[u]) return s;
        return {s[W-2:0], s[W-1]} ^ (s >> (u + 1)) ^ 32'h0F0F_0000;
    endfunction

    function automatic logic [W-1:0] golden_sig(int u);
        logic [W-1:0] l = SEED;
        logic [W-1:0] m = '0;
        for (int i = 0; i < PAT; i++) begin
            m = ((m >> 1) ^ (m[0] ? POLY : '0)) ^ good_resp(u, l);
            l = (l >> 1) ^ (l[0] ? POLY : '0);
        end
        return m;
    endfunction

    localparam logic [N-1:0][W-1:0] EXP = {32'h0, 32'h0, golden_sig(1), golden_sig(0)};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   unit_sel = '0;
    logic [W-1:0] stim, resp;
    logic         done;
    logic [N-1:0] fault_bits;

    logic [W-1:0] s0m [N];
    logic [W-1:0] s1m [N];
    int           act_unit = 0;

    int vectors = 0, errors = 0, cyc = 0, ndone = 0, tests = 0;

    always #4 clk = ~clk;

    always_comb resp = (good_resp(act_unit, stim) & ~s0m[act_unit]) | s1m[act_unit];

    bist_sequencer #(
        .W(W), .NUM_UNITS(N), .PAT_CYCLES(PAT), .SEED(SEED), .POLY(POLY),
        .DP_MASK(DPM), .EXP_SIG(EXP)
    ) i_bist_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .unit_sel(unit_sel),
        .stim(stim), .resp(resp), .done(done), .fault_bits(fault_bits)
    );

    // reference model: one queue entry per expected cycle
    logic [W-1:0] q_stim [$];
    bit           q_done [$];
    logic [N-1:0] q_flt  [$];
    string        q_tag  [$];
    string        q_ftag [$];
    logic [N-1:0] m_fault = '0;

    task automatic push(logic [W-1:0] s, bit d, logic [N-1:0] f, string t, string ft);
        q_stim.push_back(s); q_done.push_back(d); q_flt.push_back(f);
        q_tag.push_back(t);  q_ftag.push_back(ft);
    endtask

    task automatic fill(int u);
        logic [N-1:0] oldf = m_fault;
        bit           fail = 0;
        logic [W-1:0] p, r, l, m;
        push('0, 0, oldf, "R6", "R5");
        if (DPM[u]) begin
            for (int i = 0; i < 2 * W; i++) begin
                p = (i < W) ? (W'(1) << i) : ~(W'(1) << (i - W));
                push(p, 0, oldf, "R4 R8", "R5");
                r = (good_resp(u, p) & ~s0m[u]) | s1m[u];
                if (r != p) fail = 1;
            end
        end else begin
            l = SEED; m = '0;
            for (int i = 0; i < PAT; i++) begin
                push(l, 0, oldf, "R2 R8", "R5");
                r = (good_resp(u, l) & ~s0m[u]) | s1m[u];
                m = ((m >> 1) ^ (m[0] ? POLY : '0)) ^ r;
                l = (l >> 1) ^ (l[0] ? POLY : '0);
            end
            fail = (m != EXP[u]);
        end
        push('0, 0, oldf, "R6", "R5");
        push('0, 0, oldf, "R6", "R5");
        if (fail) m_fault[u] = 1'b1;
        push('0, 1, m_fault, "R6", DPM[u] ? "R4" : "R3");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_stim.delete(); q_done.delete(); q_flt.delete(); q_tag.delete(); q_ftag.delete();
            m_fault = '0;
        end else if (q_stim.size() == 0) begin
            if (start) fill(int'(unit_sel));   // R7: only accepted when idle
        end else begin
            void'(q_stim.pop_front()); void'(q_done.pop_front()); void'(q_flt.pop_front());
            void'(q_tag.pop_front());  void'(q_ftag.pop_front());
        end
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (q_stim.size() != 0) begin
                chk(q_tag[0], stim, q_stim[0]);
                chk("R6", W'(done), W'(q_done[0]));
                chk(q_ftag[0], W'(fault_bits), W'(q_flt[0]));
            end else begin
                chk("R6", stim, '0);
                chk("R6", W'(done), '0);
                chk("R5", W'(fault_bits), W'(m_fault));
            end
            if (done) ndone++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_test(int u);
        @(negedge clk);
        unit_sel = 2'(u); act_unit = u; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        tests++;
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin s0m[k] = '0; s1m[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", stim, '0);
        chk("R1", W'(done), '0);
        chk("R1", W'(fault_bits), '0);

        run_test(0);                        // R3 clean control unit
        s1m[1] = 32'h0000_0080;
        run_test(1);                        // R3 stuck-at-1 bit 7
        s1m[1] = '0;
        run_test(2);                        // R4 clean datapath
        s0m[3] = 32'h8000_0000;
        run_test(3);                        // R4 stuck-at-0 bit 31
        s0m[3] = '0;
        run_test(3);                        // R5 clean retest stays faulty

        // R7: stray start aimed at clean unit 2 in mid-test
        @(negedge clk);
        unit_sel = 2'd0; act_unit = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        unit_sel = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0; unit_sel = 2'd0;
        wait_done();
        tests++;
        chk("R7", W'(fault_bits[2]), '0);

        // R7: start held through DONE, stuck-at-1 bit 0 on datapath 2
        s1m[2] = 32'h0000_0001;
        @(negedge clk);
        unit_sel = 2'd2; act_unit = 2; start = 1'b1;
        while (!done) @(negedge clk);
        tests++;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        tests++;
        s1m[2] = '0;

        repeat (3) @(negedge clk);
        chk("R3", W'(fault_bits[1]), W'(1'b1));
        chk("R4", W'(fault_bits[3]), W'(1'b1));
        chk("R5", W'(fault_bits), W'(4'b1110));
        chk("R6", W'(ndone), W'(tests));
        summary();
    end
endmodule